// File: doc/BRIEF.md
# Vector Double-to-Word Integer Converter

This block turns IEEE binary64 values held in a 128-bit source operand into 32-bit integers, signed or unsigned. Fractions are always truncated toward zero. A scalar form converts only the low doubleword. A vector form converts both doublewords, each on its own. Every 32-bit result fills both words of its doubleword, so later consumers may read either word.

A conversion starts when `valid_i` is high with the operand and the mode selects. One clock later the whole 128-bit result is registered and `done_o` pulses. Each lane reports two flags: invalid (NaN, infinity or out-of-range) and inexact (fraction dropped). These flags are ORed into two sticky status bits, which only reset clears.

Top module: `f64_word_cvt`

## Requirements
- R1: Lane i reads `src_i[64i+63:64i]` as binary64: sign at bit 63, an 11-bit biased exponent (bias 1023) at bits 62:52, and the fraction at bits 51:0. Lane i writes its truncated-toward-zero integer to `res_o[64i+31:64i]`. The signed target covers -2^31 to 2^31-1. The unsigned target covers 0 to 2^32-1.
- R2: Whenever `done_o` is high, `res_o[64i+63:64i+32]` equals `res_o[64i+31:64i]` for every lane.
- R3: A NaN operand (exponent all ones, fraction nonzero) gives 0x80000000 for the signed target and 0x00000000 for the unsigned target. It sets that lane's invalid flag and clears its inexact flag.
- R4: An infinity, or a finite operand whose truncated value lies outside the target range, saturates and sets invalid with inexact clear. The signed target gives 0x7FFFFFFF for positive and 0x80000000 for negative. The unsigned target gives 0xFFFFFFFF for positive and 0 for negative.
- R5: An in-range operand with a nonzero fraction sets inexact only. Any operand with magnitude below 1, including subnormals and negatives with either target, gives 0 with inexact only. An exact zero of either sign raises no flag.
- R6: With `vector_i`=0, only lane 0 is converted. `res_o[127:64]` is zero and lane 1's flags are zero, whatever `src_i[127:64]` holds.
- R7: With `vector_i`=1, both lanes are converted independently, each with its own flags.
- R8: `done_o` is high exactly in the cycle after each cycle with `valid_i` high. Results and lane flags all update at that edge. Without `valid_i` they hold their values.
- R9: The sticky invalid and inexact outputs are the OR of the lane flags of every conversion accepted since reset. They are visible together with that conversion's `done_o`.
- R10: During reset, `res_o`, `done_o`, the lane flags and the sticky flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Starts a conversion this cycle |
| src_i | input | 128 | Two binary64 operands, lane 0 in the low doubleword |
| signed_i | input | 1 | 1: signed 32-bit target, 0: unsigned |
| vector_i | input | 1 | 1: convert both lanes, 0: lane 0 only |
| res_o | output | 128 | Registered result, each word pair replicated |
| done_o | output | 1 | Result valid pulse, one cycle after `valid_i` |
| lane_invalid_o | output | 2 | Per-lane invalid flags of the last conversion |
| lane_inexact_o | output | 2 | Per-lane inexact flags of the last conversion |
| sticky_invalid_o | output | 1 | Accumulated invalid status |
| sticky_inexact_o | output | 1 | Accumulated inexact status |

## Verification
The assertions check these on every cycle:
- the one-cycle `valid_i`-to-`done_o` timing and the holding of the outputs while idle;
- the word replication inside each doubleword;
- the zeroing of the upper lane in scalar mode;
- that invalid and inexact never rise together on a lane;
- that the sticky bits never fall and always catch any flag raised by an accepted conversion.

Whether each numeric result is correct can only be shown by the bench's scenarios. These compare against a real-number model and cover:
- truncation of positive and negative fractions;
- the exact signed minimum, with and without a dropped fraction;
- the unsigned maximum and the first value beyond it;
- infinities, NaNs and subnormals under both targets;
- random operands clustered around the 2^31 and 2^32 range edges.

// File: rtl/f64_word_cvt_pkg.sv
package f64_word_cvt_pkg;

  // operand class seen by a lane
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_TINY,
    CLS_NORM,
    CLS_HUGE,
    CLS_INF,
    CLS_NAN
  } fp_cls_e;

endpackage

// File: rtl/f64_word_cvt_class.sv
module f64_word_cvt_class
  import f64_word_cvt_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int DW    = 1 + EXP_W + FRAC_W,
  localparam int SH_W  = $clog2(INT_W)
) (
  input  logic [DW-1:0]   op_i,
  output fp_cls_e         cls_o,
  output logic [SH_W-1:0] sh_o,
  output logic            sign_o
);

  localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EX_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EX_TOP = EXP_W'(BIAS + INT_W);

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_ones, ex_zero, fr_zero;

  assign sign_o  = op_i[DW-1];
  assign ex      = op_i[DW-2:FRAC_W];
  assign fr      = op_i[FRAC_W-1:0];
  assign ex_ones = &ex;
  assign ex_zero = ~|ex;
  assign fr_zero = ~|fr;
  // unbiased exponent, meaningful only for CLS_NORM
  assign sh_o    = SH_W'(ex - EX_ONE);

  always_comb begin
    if (ex_ones)           cls_o = fr_zero ? CLS_INF : CLS_NAN;
    else if (ex_zero)      cls_o = fr_zero ? CLS_ZERO : CLS_TINY;
    else if (ex < EX_ONE)  cls_o = CLS_TINY;
    else if (ex >= EX_TOP) cls_o = CLS_HUGE;
    else                   cls_o = CLS_NORM;
  end

endmodule

// File: rtl/f64_word_cvt_lane.sv
module f64_word_cvt_lane
  import f64_word_cvt_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int DW    = 1 + EXP_W + FRAC_W
) (
  input  logic [DW-1:0]    op_i,
  input  logic             signed_i,
  output logic [INT_W-1:0] word_o,
  output logic             invalid_o,
  output logic             inexact_o
);

  localparam int SH_W  = $clog2(INT_W);
  localparam int EXT_W = INT_W + FRAC_W;
  localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] UMAX = {INT_W{1'b1}};

  fp_cls_e         cls;
  logic [SH_W-1:0] sh;
  logic            sgn;

  f64_word_cvt_class #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .INT_W (INT_W)
  ) u_class (
    .op_i  (op_i),
    .cls_o (cls),
    .sh_o  (sh),
    .sign_o(sgn)
  );

  // hidden one placed at bit FRAC_W, then scaled by the exponent
  logic [EXT_W-1:0] ext, shifted;
  logic [INT_W-1:0] mag, sat;
  logic             frac_nz, over;

  assign ext     = {{(INT_W-1){1'b0}}, 1'b1, op_i[FRAC_W-1:0]};
  assign shifted = ext << sh;
  assign mag     = shifted[EXT_W-1:FRAC_W];
  assign frac_nz = |shifted[FRAC_W-1:0];

  always_comb begin
    if (signed_i) sat = sgn ? SMIN : SMAX;
    else          sat = sgn ? '0 : UMAX;
  end

  always_comb begin
    if (signed_i) over = sgn ? (mag > SMIN) : mag[INT_W-1];
    else          over = sgn;  // any negative with magnitude >= 1
  end

  always_comb begin
    word_o    = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    case (cls)
      CLS_NAN: begin
        word_o    = signed_i ? SMIN : '0;
        invalid_o = 1'b1;
      end
      CLS_INF, CLS_HUGE: begin
        word_o    = sat;
        invalid_o = 1'b1;
      end
      CLS_TINY: inexact_o = 1'b1;
      CLS_NORM: begin
        if (over) begin
          word_o    = sat;
          invalid_o = 1'b1;
        end else begin
          word_o    = sgn ? (~mag + 1'b1) : mag;
          inexact_o = frac_nz;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/f64_word_cvt_flags.sv
module f64_word_cvt_flags #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LANES-1:0] inv_i,
  input  logic [LANES-1:0] inx_i,
  output logic             sticky_inv_o,
  output logic             sticky_inx_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_inv_o <= 1'b0;
      sticky_inx_o <= 1'b0;
    end else if (valid_i) begin
      sticky_inv_o <= sticky_inv_o | (|inv_i);
      sticky_inx_o <= sticky_inx_o | (|inx_i);
    end
  end

  // R9
  sticky_inv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_inv_o |=> sticky_inv_o);
  // R9
  sticky_inx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_inx_o |=> sticky_inx_o);
  // R9
  sticky_inv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (|inv_i)) |=> sticky_inv_o);
  // R9
  sticky_inx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (|inx_i)) |=> sticky_inx_o);
  // R9
  sticky_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(sticky_inv_o) && $stable(sticky_inx_o)));

endmodule

// File: rtl/f64_word_cvt.sv
module f64_word_cvt
  import f64_word_cvt_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  parameter int LANES  = 2,
  localparam int DW    = 1 + EXP_W + FRAC_W,
  localparam int OW    = 2 * INT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [LANES*DW-1:0] src_i,
  input  logic                signed_i,
  input  logic                vector_i,
  output logic [LANES*OW-1:0] res_o,
  output logic                done_o,
  output logic [LANES-1:0]    lane_invalid_o,
  output logic [LANES-1:0]    lane_inexact_o,
  output logic                sticky_invalid_o,
  output logic                sticky_inexact_o
);

  logic [INT_W-1:0]    word_w [LANES];
  logic                inv_w  [LANES];
  logic                inx_w  [LANES];
  logic                act_w  [LANES];
  logic [LANES*OW-1:0] res_d;
  logic [LANES-1:0]    inv_d, inx_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign act_w[g] = (g == 0) ? 1'b1 : vector_i;

    f64_word_cvt_lane #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W),
      .INT_W (INT_W)
    ) u_lane (
      .op_i     (src_i[g*DW +: DW]),
      .signed_i (signed_i),
      .word_o   (word_w[g]),
      .invalid_o(inv_w[g]),
      .inexact_o(inx_w[g])
    );

    // R2
    word_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (res_o[g*OW +: INT_W] == res_o[g*OW+INT_W +: INT_W]));
    // R3 R4 R5
    flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lane_invalid_o[g] && lane_inexact_o[g]));

    if (g > 0) begin : g_upper
      // R6
      scalar_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !vector_i) |=>
          (res_o[g*OW +: OW] == '0 && !lane_invalid_o[g] && !lane_inexact_o[g]));
    end
  end

  // inactive lanes contribute zeros and no flags
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      res_d[l*OW +: OW] = act_w[l] ? {word_w[l], word_w[l]} : '0;
      inv_d[l]          = act_w[l] & inv_w[l];
      inx_d[l]          = act_w[l] & inx_w[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o          <= '0;
      lane_invalid_o <= '0;
      lane_inexact_o <= '0;
      done_o         <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        res_o          <= res_d;
        lane_invalid_o <= inv_d;
        lane_inexact_o <= inx_d;
      end
    end
  end

  f64_word_cvt_flags #(
    .LANES(LANES)
  ) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .inv_i       (inv_d),
    .inx_i       (inx_d),
    .sticky_inv_o(sticky_invalid_o),
    .sticky_inx_o(sticky_inexact_o)
  );

  // R8
  done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R8
  done_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(lane_invalid_o) && $stable(lane_inexact_o)));

endmodule

// File: tb/tb_f64_word_cvt.sv
module tb_f64_word_cvt;

  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 400;
  localparam int WD_LIMIT   = 100000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src_i = '0;
  logic         signed_i = 1'b0;
  logic         vector_i = 1'b0;
  logic [127:0] res_o;
  logic         done_o;
  logic [1:0]   lane_invalid_o, lane_inexact_o;
  logic         sticky_invalid_o, sticky_inexact_o;

  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  logic st_inv = 1'b0;
  logic st_inx = 1'b0;

  f64_word_cvt dut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .valid_i         (valid_i),
    .src_i           (src_i),
    .signed_i        (signed_i),
    .vector_i        (vector_i),
    .res_o           (res_o),
    .done_o          (done_o),
    .lane_invalid_o  (lane_invalid_o),
    .lane_inexact_o  (lane_inexact_o),
    .sticky_invalid_o(sticky_invalid_o),
    .sticky_inexact_o(sticky_inexact_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // real-number model of one lane
  function automatic void ref_cvt(input logic [63:0] b, input logic sg,
                                  output logic [31:0] w, output logic inv, output logic inx);
    real    r, t, lo, hi;
    longint li;
    inv = 1'b0;
    inx = 1'b0;
    if (b[62:52] == 11'h7FF && b[51:0] != 52'd0) begin
      w   = sg ? 32'h8000_0000 : 32'h0;
      inv = 1'b1;
      return;
    end
    r  = $bitstoreal(b);
    t  = (r < 0.0) ? -$floor(-r) : $floor(r);
    lo = sg ? -2147483648.0 : 0.0;
    hi = sg ? 2147483647.0 : 4294967295.0;
    if (t < lo) begin
      w = sg ? 32'h8000_0000 : 32'h0;
      inv = 1'b1;
    end else if (t > hi) begin
      w = sg ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
      inv = 1'b1;
    end else begin
      li  = longint'(t);
      w   = li[31:0];
      inx = (t != r);
    end
  endfunction

  function automatic logic [63:0] gen_dbl();
    logic [63:0] d, m;
    int          k;
    k = $urandom_range(0, 7);
    m = {$urandom, $urandom};
    if (k == 0) return m;
    d[63]    = 1'($urandom % 2);
    d[62:52] = 11'(1020 + $urandom_range(0, 36));
    d[51:0]  = (k == 1) ? 52'd0 : m[51:0];
    return d;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [127:0] s, input logic sg, input logic vc);
    logic [127:0] er;
    logic [1:0]   ei, ex;
    logic [31:0]  w;
    logic         fi, fx;
    er = '0;
    ei = '0;
    ex = '0;
    for (int l = 0; l < 2; l++) begin
      if (l == 0 || vc) begin
        ref_cvt(s[l*64 +: 64], sg, w, fi, fx);
        er[l*64 +: 64] = {w, w};
        ei[l] = fi;
        ex[l] = fx;
      end
    end
    st_inv = st_inv | (|ei);
    st_inx = st_inx | (|ex);
    @(negedge clk_i);
    src_i    = s;
    signed_i = sg;
    vector_i = vc;
    valid_i  = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    src_i   = {$urandom, $urandom, $urandom, $urandom};
    chk({tag, " result"}, res_o, er);
    chk({tag, " invalid"}, 128'(lane_invalid_o), 128'(ei));
    chk({tag, " inexact"}, 128'(lane_inexact_o), 128'(ex));
    chk({tag, " R8 done"}, 128'(done_o), 128'd1);
    chk({tag, " R2 copy"}, {res_o[31:0], res_o[95:64]}, {res_o[63:32], res_o[127:96]});
    chk({tag, " R9 sticky"}, 128'({sticky_invalid_o, sticky_inexact_o}), 128'({st_inv, st_inx}));
  endtask

  task automatic idle_chk();
    logic [127:0] prev;
    logic [3:0]   pflg;
    prev = res_o;
    pflg = {lane_invalid_o, lane_inexact_o};
    @(negedge clk_i);
    chk("R8 idle done", 128'(done_o), 128'd0);
    chk("R8 idle result", res_o, prev);
    chk("R8 idle flags", 128'({lane_invalid_o, lane_inexact_o}), 128'(pflg));
  endtask

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'd20220315));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 reset result", res_o, '0);
    chk("R10 reset done", 128'(done_o), 128'd0);
    chk("R10 reset flags", 128'({lane_invalid_o, lane_inexact_o, sticky_invalid_o, sticky_inexact_o}), 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // exact values first so sticky stays clear (R9)
    run_op("R1 exact 1.0", {64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000}, 1'b1, 1'b1);
    run_op("R5 +zero", {64'h8000_0000_0000_0000, 64'h0}, 1'b0, 1'b1);
    run_op("R1 exact -2^31", {64'h0, 64'hC1E0_0000_0000_0000}, 1'b1, 1'b0);
    idle_chk();
    run_op("R1 R5 trunc 3.75", {64'h0, 64'h400E_0000_0000_0000}, 1'b1, 1'b0);
    run_op("R1 trunc -3.75", {64'h0, 64'hC00E_0000_0000_0000}, 1'b1, 1'b0);
    run_op("R5 -0.5 unsigned", {64'h0, 64'hBFE0_0000_0000_0000}, 1'b0, 1'b0);
    run_op("R5 -0.5 signed", {64'h0, 64'hBFE0_0000_0000_0000}, 1'b1, 1'b0);
    run_op("R5 subnormal", {64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001}, 1'b1, 1'b1);
    run_op("R5 -2^31-0.5", {64'h0, 64'hC1E0_0000_0010_0000}, 1'b1, 1'b0);
    run_op("R1 2^32-1 unsigned", {64'h0, 64'h41EF_FFFF_FFE0_0000}, 1'b0, 1'b0);
    run_op("R1 2^31-1 signed", {64'h0, 64'h41DF_FFFF_FFC0_0000}, 1'b1, 1'b0);
    run_op("R3 NaN signed", {64'h0, 64'h7FF8_0000_0000_0000}, 1'b1, 1'b0);
    run_op("R3 NaN unsigned", {64'hFFF0_0000_0000_0001, 64'h7FF8_0000_0000_0000}, 1'b0, 1'b1);
    run_op("R4 +inf signed", {64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000}, 1'b1, 1'b1);
    run_op("R4 inf unsigned", {64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000}, 1'b0, 1'b1);
    run_op("R4 2^31 signed", {64'h0, 64'h41E0_0000_0000_0000}, 1'b1, 1'b0);
    run_op("R4 -2^31-1 signed", {64'h0, 64'hC1E0_0000_0020_0000}, 1'b1, 1'b0);
    run_op("R4 2^32 unsigned", {64'h0, 64'h41F0_0000_0000_0000}, 1'b0, 1'b0);
    run_op("R4 -1.0 unsigned", {64'h0, 64'hBFF0_0000_0000_0000}, 1'b0, 1'b0);
    run_op("R7 independent lanes", {64'h4004_0000_0000_0000, 64'h7FF8_0000_0000_0000}, 1'b1, 1'b1);
    run_op("R6 scalar masks lane1", {64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000}, 1'b0, 1'b0);
    idle_chk();

    for (int i = 0; i < N_RAND; i++) begin
      a = gen_dbl();
      b = gen_dbl();
      run_op("R1 R7 random", {b, a}, 1'($urandom % 2), 1'($urandom % 2));
      if (i % 16 == 0) idle_chk();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule